// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block collects 128 interrupt request lines and decides which one, if any, the processor should service next. Software assigns each line a 4-bit priority through a small register bus. The controller compares the pending lines with a current-priority threshold. When at least one line is strictly above that threshold, it raises a request to the processor and presents a 9-bit vector naming the winning line. Eight of the lines can also be raised and dropped by software writes. Lines 0 to 7 are the logical OR of their hardware input and a software-held pending bit.

The processor side works as a valid/ready pair. `irq_req` is the valid signal and `irq_ack` is the ready signal. Once `irq_req` is high, it stays high and `irq_vec` stays unchanged until an acknowledge is seen, whatever the sources do in the meantime; this is the back-pressure rule. On acknowledge, the controller pushes the old threshold onto a 16-entry LIFO and raises the threshold to the priority of the line being serviced. A later higher-priority line can then preempt the running handler. An end-of-service write pops the LIFO and restores the previous threshold. Software can also write the threshold directly to raise it around a shared resource (priority ceiling).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, the threshold reads 0, every priority reads 0, and the software pending bits read 0.
- R2: A request is raised only for a line whose priority is strictly greater than the threshold. A line with priority 0 never raises a request.
- R3: Among eligible lines, the highest priority wins. On a tie, the lowest-numbered line wins.
- R4: `irq_vec` equals the winning line's index, zero-extended to 9 bits.
- R5: While `irq_req` is high and `irq_ack` is low, `irq_req` stays high and `irq_vec` stays stable in every following cycle, even if the sources change.
- R6: An acknowledge takes effect on a clock edge where both `irq_ack` and `irq_req` are 1. After that edge, `irq_req` is 0 and the threshold equals the serviced priority. The old threshold is pushed on the LIFO.
- R7: A write to the end-of-service address pops the LIFO into the threshold. If the LIFO is empty, the write is ignored. An acknowledge and a pop in the same cycle resolve in favour of the acknowledge.
- R8: A write to the threshold address sets the threshold directly, and the threshold is readable at the same address. A request that was not eligible becomes eligible, or the reverse, according to the new value.
- R9: A write to the set address sets each software pending bit i (0 to 7) whose data bit i is 1. A write to the clear address clears each such bit. A bit stays pending until it is cleared.
- R10: Address map on an 8-bit bus address:
  - 0x00–0x7F: priority of line `addr`, held in data bits [3:0].
  - 0x80: threshold, bits [3:0].
  - 0x81: end-of-service.
  - 0x82: software set.
  - 0x83: software clear.
  - 0x84: software pending bits, read only, bits [7:0].
  
  Reads are combinational.
- R11: Nested preemption works to a depth of 15. Each acknowledged line raises the threshold, and successive end-of-service writes restore the thresholds in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 128 | Level-sensitive hardware request lines |
| irq_req | output | 1 | Request to the processor (valid) |
| irq_vec | output | 9 | Vector of the requested line, held while `irq_req` is high |
| irq_ack | input | 1 | Processor accepts the current vector (ready) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |

## Verification
The assertions assume that `irq_ack` is a sampled handshake: an acknowledge counts only on an edge where `irq_req` is 1. They also assume that bus writes are single-cycle strobes with a stable address. The bench drives all inputs on the falling edge and pulses `irq_ack` for exactly one cycle, only after it has seen `irq_req` high. It clears the sources before each end-of-service write, so that a line that is still active cannot relatch against the restored threshold. It also keeps the LIFO within its depth by pairing every acknowledge with one pop.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // control register offsets above the priority window
  localparam int unsigned OFS_MASK   = 0;
  localparam int unsigned OFS_EOI    = 1;
  localparam int unsigned OFS_SWSET  = 2;
  localparam int unsigned OFS_SWCLR  = 3;
  localparam int unsigned OFS_SWPEND = 4;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC  = 128,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]             src,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]            thresh,
  output logic                         win_valid,
  output logic [IDX_W-1:0]             win_idx,
  output logic [PRIO_W-1:0]            win_prio
);
  // ascending scan, strict compare: ties keep the lower index
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = thresh;
    for (int i = 0; i < N_SRC; i++) begin
      if (src[i] && prio[i] > win_prio) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_stack.sv
module prio_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top_data,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] top_i;

  assign empty    = (count == '0);
  assign top_i    = count - CW'(1);
  assign top_data = empty ? '0 : mem[top_i[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push) begin
      if (count < CW'(DEPTH)) begin
        mem[count[AW-1:0]] <= push_data;
        count <= count + CW'(1);
      end
    end else if (pop && !empty) begin
      count <= count - CW'(1);
    end
  end

  a_r7_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && count != '0 |=> count == $past(count) - CW'(1));
  a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && count == '0 |=> count == '0);
  a_r11_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    push && count < CW'(DEPTH) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 128,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned N_SW   = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  input  logic [PRIO_W-1:0]            thresh,
  output logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output logic [N_SW-1:0]              sw_pend,
  output logic                         thresh_wr,
  output logic                         eoi_wr
);
  logic           in_ctrl;
  logic [IDX_W-1:0] ofs;
  logic           set_wr, clr_wr;

  assign in_ctrl   = addr[ADDR_W-1];
  assign ofs       = addr[IDX_W-1:0];
  assign thresh_wr = we && in_ctrl && ofs == IDX_W'(OFS_MASK);
  assign eoi_wr    = we && in_ctrl && ofs == IDX_W'(OFS_EOI);
  assign set_wr    = we && in_ctrl && ofs == IDX_W'(OFS_SWSET);
  assign clr_wr    = we && in_ctrl && ofs == IDX_W'(OFS_SWCLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio <= '0;
    else if (we && !in_ctrl) prio[ofs] <= wdata[PRIO_W-1:0];
  end

  for (genvar g = 0; g < N_SW; g++) begin : g_sw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sw_pend[g] <= 1'b0;
      else if (set_wr && wdata[g]) sw_pend[g] <= 1'b1;
      else if (clr_wr && wdata[g]) sw_pend[g] <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (!in_ctrl) rdata = DATA_W'(prio[ofs]);
    else if (ofs == IDX_W'(OFS_MASK))   rdata = DATA_W'(thresh);
    else if (ofs == IDX_W'(OFS_SWPEND)) rdata = DATA_W'(sw_pend);
  end

  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (sw_pend & $past(wdata[N_SW-1:0])) == $past(wdata[N_SW-1:0]));
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (sw_pend & $past(wdata[N_SW-1:0])) == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_SRC  = 128,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned N_SW   = 8,
  parameter int unsigned VEC_W  = 9,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(N_SRC),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [N_SW-1:0]   sw_pend;
  logic              thresh_wr, eoi_wr;
  logic [PRIO_W-1:0] thresh_q;
  logic [N_SRC-1:0]  src_eff;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              req_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] held_prio;
  logic              take;
  logic              pop_en;
  logic [PRIO_W-1:0] stk_top;
  logic              stk_empty;

  irq_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .N_SW(N_SW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .thresh(thresh_q), .prio(prio), .sw_pend(sw_pend),
    .thresh_wr(thresh_wr), .eoi_wr(eoi_wr)
  );

  assign src_eff = irq_src | N_SRC'(sw_pend);

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .src(src_eff), .prio(prio), .thresh(thresh_q),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign take   = irq_ack && req_q;
  assign pop_en = eoi_wr && !take;

  prio_stack #(.DEPTH(DEPTH), .W(PRIO_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .push_data(thresh_q),
    .pop(pop_en), .top_data(stk_top), .empty(stk_empty)
  );

  // handshake register: latch only when idle, release on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      vec_q     <= '0;
      held_prio <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && win_valid) begin
      req_q     <= 1'b1;
      vec_q     <= VEC_W'(win_idx);
      held_prio <= win_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     thresh_q <= '0;
    else if (take)                  thresh_q <= held_prio;
    else if (pop_en && !stk_empty)  thresh_q <= stk_top;
    else if (thresh_wr)             thresh_q <= bus_wdata[PRIO_W-1:0];
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));
  a_r6_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req && thresh_q == $past(held_prio));
  a_r2_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> held_prio > $past(thresh_q));
  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec < VEC_W'(N_SRC));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [127:0] irq_src = '0;
  logic         irq_req;
  logic [8:0]   irq_vec;
  logic         irq_ack = 0;
  logic         bus_we = 0;
  logic [7:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [7:0] A_MASK = 8'h80, A_EOI = 8'h81, A_SET = 8'h82,
                         A_CLR = 8'h83, A_PEND = 8'h84;

  always #5 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic serve();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req", irq_req, 0);
    rd(A_MASK, v); chk("R1 thresh", v, 0);
    rd(A_PEND, v); chk("R1 swpend", v, 0);
    rd(8'd77, v);  chk("R1 prio", v, 0);

    // R2 R4 R6 R7 R10 sweep over every line
    for (int i = 0; i < 128; i++) begin
      int p, m;
      p = (i * 5 + 3) % 16;
      m = (i * 3) % 16;
      wr(8'(i), 8'(p));
      rd(8'(i), v); chk("R10 prio readback", v, p);
      wr(A_MASK, 8'(m));
      @(negedge clk); irq_src = '0; irq_src[i] = 1'b1;
      settle();
      chk("R2 eligibility", irq_req, (p > m) ? 1 : 0);
      if (p > m) begin
        chk("R4 vector", irq_vec, i);
        serve();
        chk("R6 req drops", irq_req, 0);
        rd(A_MASK, v); chk("R6 thresh raised", v, p);
        irq_src = '0;
        wr(A_EOI, 8'h00);
        rd(A_MASK, v); chk("R7 thresh restored", v, m);
      end else begin
        irq_src = '0;
      end
      wr(8'(i), 8'h00);
    end
    wr(A_MASK, 8'h00);

    // R3 tie: lowest index wins; R5 hold while unacknowledged
    wr(8'd5, 8'd9); wr(8'd40, 8'd9); wr(8'd100, 8'd9);
    @(negedge clk); irq_src[5] = 1; irq_src[40] = 1; irq_src[100] = 1;
    settle();
    chk("R3 tie", irq_vec, 5);
    wr(8'd100, 8'd14);
    irq_src[5] = 0;
    repeat (3) @(negedge clk);
    chk("R5 req held", irq_req, 1);
    chk("R5 vec held", irq_vec, 5);
    serve();
    // thresh now 9; line 100 at 14 wins next
    @(negedge clk);
    chk("R3 higher priority", irq_vec, 100);
    serve();
    irq_src = '0;
    wr(A_EOI, 0); wr(A_EOI, 0);
    rd(A_MASK, v); chk("R7 unwind", v, 0);
    wr(8'd5, 0); wr(8'd40, 0); wr(8'd100, 0);

    // R8 ceiling write
    wr(8'd60, 8'd10); wr(8'd61, 8'd11);
    wr(A_MASK, 8'd10);
    rd(A_MASK, v); chk("R8 thresh readback", v, 10);
    @(negedge clk); irq_src[60] = 1;
    settle();
    chk("R8 blocked at ceiling", irq_req, 0);
    irq_src[61] = 1;
    settle();
    chk("R8 above ceiling", irq_vec, 61);
    serve(); irq_src = '0;
    wr(A_EOI, 0);
    rd(A_MASK, v); chk("R8 ceiling restored", v, 10);
    wr(A_MASK, 0); wr(8'd60, 0); wr(8'd61, 0);

    // R11 nested preemption 15 deep
    for (int k = 1; k <= 15; k++) wr(8'(19 + k), 8'(k));
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk); irq_src[19 + k] = 1;
      settle();
      chk("R11 preempt vec", irq_vec, 19 + k);
      serve();
      rd(A_MASK, v); chk("R11 nest thresh", v, k);
    end
    irq_src = '0;
    for (int k = 14; k >= 0; k--) begin
      wr(A_EOI, 0);
      rd(A_MASK, v); chk("R11 unwind thresh", v, k);
    end
    wr(A_EOI, 0);
    rd(A_MASK, v); chk("R7 empty pop ignored", v, 0);
    for (int k = 1; k <= 15; k++) wr(8'(19 + k), 0);

    // R9 software lines
    wr(8'd5, 8'd6); wr(8'd7, 8'd6);
    wr(A_SET, 8'hA5);
    rd(A_PEND, v); chk("R9 set", v, 8'hA5);
    settle();
    chk("R9 sw vector", irq_vec, 5);
    repeat (5) @(negedge clk);
    rd(A_PEND, v); chk("R9 sticky", v, 8'hA5);
    wr(A_CLR, 8'h20);
    rd(A_PEND, v); chk("R9 clear", v, 8'h85);
    serve();
    wr(A_EOI, 0);
    @(negedge clk);
    chk("R9 next sw vector", irq_vec, 7);
    wr(A_CLR, 8'hFF);
    rd(A_PEND, v); chk("R9 clear all", v, 0);
    serve();
    wr(A_EOI, 0);
    settle();
    chk("R9 idle", irq_req, 0);
    rd(A_MASK, v); chk("R9 thresh back", v, 0);

    finish_run();
  end
endmodule